// File: doc/BRIEF.md
# Program Status Word and Exception Entry Unit

This block keeps the 32-bit program status word of a small processor core and does the register work of entering and leaving exceptions. The word holds four condition flags in its top nibble, two interrupt disable bits, a bit that selects the compact 16-bit instruction set, and a 5-bit mode field. The ALU updates the flags through a narrow port. Software writes the whole word through a second port, and privilege decides which fields the write may change.

When an exception is requested, the unit selects the most urgent request that is not masked. It stores the incoming PC and the current status word in the banked copies that belong to the target mode. It then switches mode, masks interrupts and presents the vector address for the fetch unit to load. On an exception return it copies the banked status word back into the live word. It also presents the banked return address, corrected by the amount recorded at entry.

Top module: `stat_word_ctl`

## Requirements
- R1: Synchronous reset sets the word to 0x000000D3: flags clear, reserved bits clear, I (bit 7) and F (bit 6) set, T (bit 5) clear, and mode supervisor (10011). Every bank holds a saved word of 0x000000D3 and a return address of 0. `pc_load` and `xcpt_taken` are low.
- R2: With `flag_we` high, `flag_in` = {N,Z,C,V} is loaded into bits 31:28 at the next clock edge, in any mode.
- R3: A software write (`sw_we`) made outside user mode loads bits 31:28, 7, 6 and 5 from `sw_data`. It loads bits 4:0 only when they hold a valid mode: user 10000, FIQ 10001, IRQ 10010, supervisor 10011, abort 10111, undefined 11011 or system 11111. Any other mode value leaves the mode field as it was.
- R4: A software write made in user mode changes bits 31:28 only. Bits 7:0 keep their value.
- R5: Bits 27:8 keep their current value on every flag write, software write, exception entry and return.
- R6: `xcpt_req` carries one bit per exception: bit 0 reset, bit 1 undefined, bit 2 supervisor call, bit 3 prefetch abort, bit 4 data abort, bit 5 IRQ, bit 6 FIQ. Priority runs reset, data abort, FIQ, IRQ, prefetch abort, undefined, supervisor call. IRQ is ignored while bit 7 is set, and FIQ is ignored while bit 6 is set.
- R7: On entry, the target mode's bank receives `pc_in` as its return address and the current word as its saved word. The mode field becomes the target mode. Reset and supervisor call go to supervisor mode, undefined goes to undefined mode, both aborts go to abort mode, IRQ goes to IRQ mode and FIQ goes to FIQ mode.
- R8: Entry sets I and clears T. Reset and FIQ entry also set F. The flags keep their value.
- R9: One cycle after a granted request, `xcpt_taken` and `pc_load` are high for one cycle and `pc_target` holds the vector. The vectors are reset 0x00, undefined 0x04, supervisor call 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18 and FIQ 0x1C.
- R10: `ret_req` in a banked mode (FIQ, IRQ, supervisor, abort, undefined) restores the word from the current mode's bank. One cycle later it pulses `pc_load` with `pc_target` set to the banked return address minus 4 for IRQ, FIQ and abort entries, or minus 0 for reset, undefined and supervisor call entries, wrapping modulo 2^PC_W. In user or system mode `ret_req` has no effect.
- R11: When requests arrive in the same cycle, a granted exception wins over a return, a return wins over a software write, and a software write wins over a flag update.
- R12: `cur_link` and `cur_saved` show the current mode's banked return address and saved word, and show 0 in user and system mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_we | input | 1 | ALU flag update strobe |
| flag_in | input | 4 | New N,Z,C,V flags |
| sw_we | input | 1 | Software write strobe |
| sw_data | input | 32 | Word written by software |
| xcpt_req | input | 7 | Exception request per type |
| pc_in | input | PC_W | Current PC, saved on entry |
| ret_req | input | 1 | Exception return request |
| psr_out | output | 32 | Live status word |
| pc_load | output | 1 | Fetch unit must load `pc_target` |
| pc_target | output | PC_W | Vector or return address |
| xcpt_taken | output | 1 | Pulse: an exception was entered |
| cur_link | output | PC_W | Current mode's banked return address |
| cur_saved | output | 32 | Current mode's banked saved word |

## Verification
The bench builds the unit with its default 32-bit PC width. This width lets a return from an abort entry made at address 0 wrap to 0xFFFFFFFC, and it keeps every vector inside the word. The bench nests an FIQ inside an IRQ, stacks all lower-priority requests against a data abort, and lets a supervisor call collide with a return. These cases reach every bank and every return correction.

// File: rtl/swc_pkg.sv
package swc_pkg;

    localparam int PSR_W   = 32;
    localparam int NXC     = 7;
    localparam int NBANK   = 5;
    localparam int BANK_IW = $clog2(NBANK);
    localparam int XC_IW   = $clog2(NXC);

    typedef enum logic [4:0] {
        M_USR = 5'b10000,
        M_FIQ = 5'b10001,
        M_IRQ = 5'b10010,
        M_SVC = 5'b10011,
        M_ABT = 5'b10111,
        M_UND = 5'b11011,
        M_SYS = 5'b11111
    } mode_e;

    typedef enum logic [XC_IW-1:0] {
        X_RST  = 3'd0,
        X_UND  = 3'd1,
        X_SVC  = 3'd2,
        X_PABT = 3'd3,
        X_DABT = 3'd4,
        X_IRQ  = 3'd5,
        X_FIQ  = 3'd6
    } xc_e;

    typedef struct packed {
        logic [3:0]  nzcv;
        logic [19:0] rsv;
        logic        irq_off;
        logic        fiq_off;
        logic        cmp16;
        logic [4:0]  mode;
    } psr_t;

    localparam psr_t PSR_RESET = '{nzcv: 4'h0, rsv: 20'h0, irq_off: 1'b1,
                                   fiq_off: 1'b1, cmp16: 1'b0, mode: M_SVC};

    function automatic logic mode_ok(logic [4:0] m);
        case (m)
            M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic has_bank(logic [4:0] m);
        case (m)
            M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [BANK_IW-1:0] bank_idx(logic [4:0] m);
        case (m)
            M_FIQ:   return BANK_IW'(0);
            M_IRQ:   return BANK_IW'(1);
            M_SVC:   return BANK_IW'(2);
            M_ABT:   return BANK_IW'(3);
            M_UND:   return BANK_IW'(4);
            default: return BANK_IW'(0);
        endcase
    endfunction

    function automatic logic [4:0] target_mode(xc_e t);
        case (t)
            X_RST, X_SVC:   return M_SVC;
            X_UND:          return M_UND;
            X_PABT, X_DABT: return M_ABT;
            X_IRQ:          return M_IRQ;
            default:        return M_FIQ;
        endcase
    endfunction

    function automatic logic [4:0] vector_of(xc_e t);
        case (t)
            X_RST:   return 5'h00;
            X_UND:   return 5'h04;
            X_SVC:   return 5'h08;
            X_PABT:  return 5'h0C;
            X_DABT:  return 5'h10;
            X_IRQ:   return 5'h18;
            default: return 5'h1C;
        endcase
    endfunction

    function automatic logic ret_minus4(xc_e t);
        return (t == X_PABT) || (t == X_DABT) || (t == X_IRQ) || (t == X_FIQ);
    endfunction

endpackage

// File: rtl/swc_arb.sv
module swc_arb
    import swc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NXC-1:0] req,
    input  logic           irq_off,
    input  logic           fiq_off,
    output logic [NXC-1:0] grant,
    output logic           hit,
    output xc_e            sel
);
    localparam int ORDER [NXC] = '{0, 4, 6, 5, 3, 1, 2};

    logic [NXC-1:0] eff;

    always_comb begin
        eff = req;
        eff[X_IRQ] = req[X_IRQ] & ~irq_off;
        eff[X_FIQ] = req[X_FIQ] & ~fiq_off;
    end

    always_comb begin
        grant = '0;
        hit   = 1'b0;
        sel   = X_RST;
        for (int k = NXC - 1; k >= 0; k--) begin
            if (eff[XC_IW'(ORDER[k])]) begin
                grant = '0;
                grant[XC_IW'(ORDER[k])] = 1'b1;
                hit = 1'b1;
                sel = xc_e'(XC_IW'(ORDER[k]));
            end
        end
    end

    // R6: at most one grant, and masked interrupts never win
    a_r6_one_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    a_r6_irq_masked: assert property (@(posedge clk) disable iff (rst)
        irq_off |-> !grant[X_IRQ]);
    a_r6_fiq_masked: assert property (@(posedge clk) disable iff (rst)
        fiq_off |-> !grant[X_FIQ]);
    a_r6_reset_first: assert property (@(posedge clk) disable iff (rst)
        req[X_RST] |-> grant[X_RST]);

endmodule

// File: rtl/swc_bank.sv
module swc_bank
    import swc_pkg::*;
#(
    parameter int PC_W = 32
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [BANK_IW-1:0] wr_idx,
    input  psr_t               wr_saved,
    input  logic [PC_W-1:0]    wr_link,
    input  logic               wr_adj,
    input  logic [BANK_IW-1:0] rd_idx,
    output psr_t               rd_saved,
    output logic [PC_W-1:0]    rd_link,
    output logic               rd_adj
);
    psr_t            sv_arr [NBANK];
    logic [PC_W-1:0] lk_arr [NBANK];
    logic            ad_arr [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        psr_t            sv_q;
        logic [PC_W-1:0] lk_q;
        logic            ad_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sv_q <= PSR_RESET;
                lk_q <= '0;
                ad_q <= 1'b0;
            end else if (wr_en && wr_idx == BANK_IW'(b)) begin
                sv_q <= wr_saved;
                lk_q <= wr_link;
                ad_q <= wr_adj;
            end
        end

        assign sv_arr[b] = sv_q;
        assign lk_arr[b] = lk_q;
        assign ad_arr[b] = ad_q;
    end

    always_comb begin
        rd_saved = PSR_RESET;
        rd_link  = '0;
        rd_adj   = 1'b0;
        for (int b = 0; b < NBANK; b++) begin
            if (rd_idx == BANK_IW'(b)) begin
                rd_saved = sv_arr[b];
                rd_link  = lk_arr[b];
                rd_adj   = ad_arr[b];
            end
        end
    end

    // R7: a write to the bank being read shows up on the next cycle
    a_r7_bank_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == rd_idx) ##1 (rd_idx == $past(rd_idx))
        |-> rd_link == $past(wr_link));

endmodule

// File: rtl/swc_psr.sv
module swc_psr
    import swc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flag_we,
    input  logic [3:0] flag_in,
    input  logic       sw_we,
    input  psr_t       sw_word,
    input  logic       ent,
    input  logic [4:0] ent_mode,
    input  logic       ent_fmask,
    input  logic       ret,
    input  psr_t       ret_word,
    output psr_t       cur
);
    psr_t nxt;
    logic priv;

    assign priv = (cur.mode != M_USR);

    always_comb begin
        nxt = cur;
        if (ent) begin
            nxt.mode    = ent_mode;
            nxt.irq_off = 1'b1;
            nxt.cmp16   = 1'b0;
            if (ent_fmask) nxt.fiq_off = 1'b1;
        end else if (ret) begin
            nxt     = ret_word;
            nxt.rsv = cur.rsv;
        end else if (sw_we) begin
            nxt.nzcv = sw_word.nzcv;
            if (priv) begin
                nxt.irq_off = sw_word.irq_off;
                nxt.fiq_off = sw_word.fiq_off;
                nxt.cmp16   = sw_word.cmp16;
                if (mode_ok(sw_word.mode)) nxt.mode = sw_word.mode;
            end
        end else if (flag_we) begin
            nxt.nzcv = flag_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= PSR_RESET;
        else     cur <= nxt;
    end

    // R3: the mode field only ever holds a legal encoding
    a_r3_mode_legal: assert property (@(posedge clk) disable iff (rst)
        mode_ok(cur.mode));
    // R4: a user-mode write leaves the control byte alone
    a_r4_user_ctrl: assert property (@(posedge clk) disable iff (rst)
        (cur.mode == M_USR && sw_we && !ent && !ret) |=> $stable(cur[7:0]));
    // R2: a lone flag update lands in the top nibble
    a_r2_flags: assert property (@(posedge clk) disable iff (rst)
        (flag_we && !sw_we && !ent && !ret) |=> cur.nzcv == $past(flag_in));
    // R8: entry leaves the flags alone and sets I
    a_r8_entry_flags: assert property (@(posedge clk) disable iff (rst)
        ent |=> (cur.nzcv == $past(cur.nzcv)) && cur.irq_off);

endmodule

// File: rtl/stat_word_ctl.sv
module stat_word_ctl
    import swc_pkg::*;
#(
    parameter int PC_W = 32
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                flag_we,
    input  logic [3:0]          flag_in,
    input  logic                sw_we,
    input  logic [PSR_W-1:0]    sw_data,
    input  logic [NXC-1:0]      xcpt_req,
    input  logic [PC_W-1:0]     pc_in,
    input  logic                ret_req,
    output logic [PSR_W-1:0]    psr_out,
    output logic                pc_load,
    output logic [PC_W-1:0]     pc_target,
    output logic                xcpt_taken,
    output logic [PC_W-1:0]     cur_link,
    output logic [PSR_W-1:0]    cur_saved
);
    localparam logic [PC_W-1:0] RET_ADJ = PC_W'(4);
    localparam logic [PC_W-1:0] VEC_TOP = PC_W'(28);

    psr_t               psr;
    logic [NXC-1:0]     grant;
    logic               hit;
    xc_e                sel;
    logic [4:0]         tmode;
    logic [BANK_IW-1:0] t_idx;
    logic               own_bank;
    logic [BANK_IW-1:0] own_idx;
    logic               ret_ok;
    psr_t               rd_saved;
    logic [PC_W-1:0]    rd_link;
    logic               rd_adj;

    swc_arb u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (xcpt_req),
        .irq_off (psr.irq_off),
        .fiq_off (psr.fiq_off),
        .grant   (grant),
        .hit     (hit),
        .sel     (sel)
    );

    assign tmode    = target_mode(sel);
    assign t_idx    = bank_idx(tmode);
    assign own_bank = has_bank(psr.mode);
    assign own_idx  = bank_idx(psr.mode);
    assign ret_ok   = ret_req && !hit && own_bank;

    swc_bank #(.PC_W(PC_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (hit),
        .wr_idx   (t_idx),
        .wr_saved (psr),
        .wr_link  (pc_in),
        .wr_adj   (ret_minus4(sel)),
        .rd_idx   (own_idx),
        .rd_saved (rd_saved),
        .rd_link  (rd_link),
        .rd_adj   (rd_adj)
    );

    swc_psr u_psr (
        .clk       (clk),
        .rst       (rst),
        .flag_we   (flag_we),
        .flag_in   (flag_in),
        .sw_we     (sw_we),
        .sw_word   (psr_t'(sw_data)),
        .ent       (hit),
        .ent_mode  (tmode),
        .ent_fmask (sel == X_FIQ || sel == X_RST),
        .ret       (ret_ok),
        .ret_word  (rd_saved),
        .cur       (psr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_load    <= 1'b0;
            xcpt_taken <= 1'b0;
            pc_target  <= '0;
        end else begin
            pc_load    <= hit || ret_ok;
            xcpt_taken <= hit;
            if (hit)         pc_target <= PC_W'(vector_of(sel));
            else if (ret_ok) pc_target <= rd_link - (rd_adj ? RET_ADJ : '0);
        end
    end

    assign psr_out   = psr;
    assign cur_link  = own_bank ? rd_link : '0;
    assign cur_saved = own_bank ? rd_saved : '0;

    // R9: a taken exception loads a word-aligned vector in range
    a_r9_vector: assert property (@(posedge clk) disable iff (rst)
        xcpt_taken |-> pc_load && pc_target[1:0] == 2'b00 && pc_target <= VEC_TOP);
    // R8: after entry, T is clear and I is set
    a_r8_entry_mask: assert property (@(posedge clk) disable iff (rst)
        xcpt_taken |-> psr_out[7] && !psr_out[5]);
    // R7: the new mode's return address is the PC seen at entry
    a_r7_link: assert property (@(posedge clk) disable iff (rst)
        hit |=> cur_link == $past(pc_in));
    // R10: a return restores the banked word
    a_r10_restore: assert property (@(posedge clk) disable iff (rst)
        ret_ok |=> psr_out == $past(rd_saved) && pc_load && !xcpt_taken);
    // R11: an exception beats a return in the same cycle
    a_r11_xcpt_wins: assert property (@(posedge clk) disable iff (rst)
        (ret_req && hit) |=> xcpt_taken);

endmodule

// File: tb/stat_word_ctl_test.sv
`timescale 1ns/1ps
module stat_word_ctl_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        flag_we;
    logic [3:0]  flag_in;
    logic        sw_we;
    logic [31:0] sw_data;
    logic [6:0]  xcpt_req;
    logic [31:0] pc_in;
    logic        ret_req;
    logic [31:0] psr_out;
    logic        pc_load;
    logic [31:0] pc_target;
    logic        xcpt_taken;
    logic [31:0] cur_link;
    logic [31:0] cur_saved;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    stat_word_ctl #(.PC_W(32)) uut (
        .clk(clk), .rst(rst), .flag_we(flag_we), .flag_in(flag_in),
        .sw_we(sw_we), .sw_data(sw_data), .xcpt_req(xcpt_req), .pc_in(pc_in),
        .ret_req(ret_req), .psr_out(psr_out), .pc_load(pc_load),
        .pc_target(pc_target), .xcpt_taken(xcpt_taken),
        .cur_link(cur_link), .cur_saved(cur_saved)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_psr;
    logic [31:0] m_sv [5];
    logic [31:0] m_lk [5];
    bit          m_ad [5];
    bit          m_load, m_tk;
    logic [31:0] m_tgt;
    int          m_t, m_cb, m_b;
    int          m_ord [7] = '{0, 4, 6, 5, 3, 1, 2};

    function automatic int bidx(logic [4:0] m);
        case (m)
            5'd17: return 0;
            5'd18: return 1;
            5'd19: return 2;
            5'd23: return 3;
            5'd27: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic logic [4:0] tmode(int t);
        case (t)
            0, 2: return 5'd19;
            1:    return 5'd27;
            3, 4: return 5'd23;
            5:    return 5'd18;
            default: return 5'd17;
        endcase
    endfunction

    function automatic logic [31:0] vec(int t);
        case (t)
            0: return 32'h00; 1: return 32'h04; 2: return 32'h08;
            3: return 32'h0C; 4: return 32'h10; 5: return 32'h18;
            default: return 32'h1C;
        endcase
    endfunction

    function automatic bit legal(logic [4:0] m);
        return (m == 5'd16) || (m == 5'd31) || (bidx(m) >= 0);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_psr = 32'h000000D3;
            for (int i = 0; i < 5; i++) begin
                m_sv[i] = 32'h000000D3; m_lk[i] = 0; m_ad[i] = 0;
            end
            m_load = 0; m_tk = 0; m_tgt = 0;
        end else begin
            m_t = -1;
            for (int k = 0; k < 7; k++) begin
                bit en;
                en = xcpt_req[m_ord[k]];
                if (m_ord[k] == 5 && m_psr[7]) en = 0;
                if (m_ord[k] == 6 && m_psr[6]) en = 0;
                if (en && m_t < 0) m_t = m_ord[k];
            end
            m_cb = bidx(m_psr[4:0]);
            m_load = 0; m_tk = 0;
            if (m_t >= 0) begin
                m_b = bidx(tmode(m_t));
                m_sv[m_b] = m_psr;
                m_lk[m_b] = pc_in;
                m_ad[m_b] = (m_t >= 3);
                m_psr[4:0] = tmode(m_t);
                m_psr[7] = 1'b1;
                m_psr[5] = 1'b0;
                if (m_t == 0 || m_t == 6) m_psr[6] = 1'b1;
                m_tgt = vec(m_t);
                m_load = 1; m_tk = 1;
            end else if (ret_req && m_cb >= 0) begin
                m_psr = m_sv[m_cb];
                m_tgt = m_lk[m_cb] - (m_ad[m_cb] ? 32'd4 : 32'd0);
                m_load = 1;
            end else if (sw_we) begin
                m_psr[31:28] = sw_data[31:28];
                if (m_psr[4:0] != 5'd16) begin
                    m_psr[7:5] = sw_data[7:5];
                    if (legal(sw_data[4:0])) m_psr[4:0] = sw_data[4:0];
                end
            end else if (flag_we) begin
                m_psr[31:28] = flag_in;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            m_cb = bidx(m_psr[4:0]);
            chk("R3 model psr", psr_out, m_psr);
            chk("R9 model load", {31'd0, pc_load}, {31'd0, m_load});
            chk("R9 model taken", {31'd0, xcpt_taken}, {31'd0, m_tk});
            chk("R10 model target", pc_target, m_tgt);
            chk("R12 model link", cur_link, (m_cb >= 0) ? m_lk[m_cb] : 32'd0);
            chk("R12 model saved", cur_saved, (m_cb >= 0) ? m_sv[m_cb] : 32'd0);
        end
    end

    // ---------------- stimulus ----------------
    task automatic clear_in();
        flag_we = 0; flag_in = 0; sw_we = 0; sw_data = 0;
        xcpt_req = 0; pc_in = 0; ret_req = 0;
    endtask

    task automatic apply();
        @(negedge clk);
        clear_in();
    endtask

    initial begin
        clear_in();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 reset word", psr_out, 32'h000000D3);
        chk("R1 reset load", {31'd0, pc_load}, 32'd0);
        chk("R1 reset saved", cur_saved, 32'h000000D3);

        flag_we = 1; flag_in = 4'hA; apply();
        chk("R2 flag update", psr_out, 32'hA00000D3);

        sw_we = 1; sw_data = 32'h000000E5; apply();
        chk("R3 invalid mode kept", psr_out, 32'h000000F3);

        sw_we = 1; sw_data = 32'h5FFFFF10; apply();
        chk("R3 write to user", psr_out, 32'h50000010);
        chk("R5 reserved kept", {12'd0, psr_out[27:8]}, 32'd0);

        sw_we = 1; sw_data = 32'h800000DF; apply();
        chk("R4 user write flags only", psr_out, 32'h80000010);

        ret_req = 1; apply();
        chk("R10 user return ignored", psr_out, 32'h80000010);
        chk("R10 user return no load", {31'd0, pc_load}, 32'd0);

        sw_we = 1; sw_data = 32'h30000000; flag_we = 1; flag_in = 4'hF; apply();
        chk("R11 write beats flags", psr_out, 32'h30000010);

        xcpt_req = 7'b0100000; pc_in = 32'h1000; apply();
        chk("R8 irq entry word", psr_out, 32'h30000092);
        chk("R9 irq vector", pc_target, 32'h18);
        chk("R7 irq link", cur_link, 32'h1000);
        chk("R7 irq saved", cur_saved, 32'h30000010);

        xcpt_req = 7'b0100000; pc_in = 32'h1234; apply();
        chk("R6 irq masked", {31'd0, xcpt_taken}, 32'd0);

        xcpt_req = 7'b1000000; pc_in = 32'h2004; apply();
        chk("R8 fiq entry sets F", psr_out, 32'h300000D1);
        chk("R9 fiq vector", pc_target, 32'h1C);

        ret_req = 1; apply();
        chk("R10 fiq return word", psr_out, 32'h30000092);
        chk("R10 fiq return pc", pc_target, 32'h2000);

        ret_req = 1; apply();
        chk("R10 irq return pc", pc_target, 32'h0FFC);
        chk("R10 irq return word", psr_out, 32'h30000010);

        xcpt_req = 7'b0011110; pc_in = 32'h300; apply();
        chk("R6 data abort wins", pc_target, 32'h10);
        chk("R7 abort mode", psr_out, 32'h30000097);

        ret_req = 1; xcpt_req = 7'b0000100; pc_in = 32'h44; apply();
        chk("R11 call beats return", pc_target, 32'h08);
        chk("R11 call word", psr_out, 32'h30000093);

        ret_req = 1; apply();
        chk("R10 call return no adjust", pc_target, 32'h44);
        chk("R10 back to abort", psr_out, 32'h30000097);

        ret_req = 1; apply();
        chk("R10 abort return", pc_target, 32'h2FC);

        xcpt_req = 7'b0001000; pc_in = 32'h0; apply();
        chk("R9 prefetch vector", pc_target, 32'h0C);
        ret_req = 1; apply();
        chk("R10 wrap", pc_target, 32'hFFFFFFFC);

        xcpt_req = 7'b1000001; pc_in = 32'h55; apply();
        chk("R6 reset beats fiq", pc_target, 32'h00);
        chk("R8 reset entry", psr_out, 32'h300000D3);

        xcpt_req = 7'b0000110; pc_in = 32'h77; apply();
        chk("R6 undefined beats call", pc_target, 32'h04);
        chk("R7 undefined saved", cur_saved, 32'h300000D3);

        sw_we = 1; sw_data = 32'h0000001F; apply();
        chk("R12 system no bank", cur_link, 32'h0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule